// File: doc/BRIEF.md
# Rank-Order Codeword Decoder

This block sits behind a comparator network that sorts eight line samples by level. Once per unit interval it receives, for every wire, that wire's place in the sort. It never compares a level against a fixed threshold. The two wires ranked highest are read as +1, the two ranked lowest as -1, and the four in the middle as common mode (0). The positions of the four non-zero wires form a 4-of-8 subset, and the placement of the two +1 symbols within that subset carries two more bits. Together they give back one data byte.

A second, pairwise mode treats the eight wires as four differential pairs and returns four bits per interval. If the input vector is not a true ordering, or it names a codeword outside the 256-entry set, the vector is flagged. The output byte then keeps its last good value, and a saturating error counter advances. Output is registered one cycle after the input, and a valid strobe travels with it.

Top module: `rank_codeword_decoder`

## Requirements
- R1: `rank_vec[3i+2:3i]` holds the rank of wire i, where 0 means highest and 7 lowest. Ranks 0 and 1 denote +1, ranks 6 and 7 denote -1, and ranks 2 to 5 denote 0. In code mode, `out_data[7:2]` is the subset index. The subset index is the count of 8-bit masks that have exactly four bits set and are numerically smaller than the active mask, where bit i of the mask is set when wire i is non-zero.
- R2: In code mode, number the four non-zero wires in ascending wire order. If +1 sits on the first and second of them, `out_data[1:0]` is 0. First and third gives 1, first and fourth gives 2, and second and third gives 3.
- R3: Any reordering of ranks within the top pair, within the bottom pair or within the middle four yields the same byte.
- R4: A rank vector that is not a permutation of 0..7 sets `out_err`, and `out_data` keeps its previous value. This holds in both modes.
- R5: In code mode, a subset index of 64 or more, or a +1 placement not listed in R2, sets `out_err`, and `out_data` keeps its previous value.
- R6: In pair mode (`mode_legacy`=1), `out_data[j]` is 1 when the rank of wire 2j is numerically smaller than the rank of wire 2j+1, for j=0..3. `out_data[7:4]` is 0.
- R7: `out_valid` equals `in_valid` from one clock earlier. When `in_valid` is low, `out_data` does not change.
- R8: `out_err` is high only together with `out_valid`, and only for the vector that was flagged.
- R9: `err_count` rises by one for each flagged vector and stops at 2^CNT_W-1.
- R10: `err_clr` sets `err_count` to 0 on the next clock and takes priority over an increment in the same cycle.
- R11: While `rst_n` is low, `out_valid`, `out_err`, `out_data` and `err_count` are set to 0 at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A rank vector is present this cycle |
| mode_legacy | input | 1 | 1 selects four-pair mode, 0 selects code mode |
| rank_vec | input | 24 | Eight 3-bit ranks, wire i at bits 3i+2:3i |
| err_clr | input | 1 | Clears the error counter |
| out_valid | output | 1 | Registered result present |
| out_err | output | 1 | Registered vector was illegal |
| out_data | output | 8 | Decoded byte, or pair bits in [3:0] |
| err_count | output | CNT_W | Saturating count of flagged vectors |

## Verification
The properties assume that `in_valid`, `mode_legacy` and `err_clr` carry known values at every edge after reset, and that reset is asserted at the first clock. They do not assume that `rank_vec` is legal. Duplicate ranks and out-of-set codewords are part of the legal input space, so the stimulus drives every control input to a defined level from time zero, holds reset over the opening edges, and deliberately mixes illegal vectors with legal ones. Each of the 256 bytes is rebuilt from subset masks with shuffled ranks inside each class. Out-of-set subsets and placements, pair-mode permutations and a long run of flagged vectors that forces saturation are also driven.

// File: rtl/rank_dec_pkg.sv
// Package: shared sizes, the ternary symbol type and a constant binomial helper.
// Assumes eight wires with 3-bit ranks; widths derive from WIRES.
package rank_dec_pkg;
    localparam int unsigned WIRES     = 8;
    localparam int unsigned RANK_W    = $clog2(WIRES);
    localparam int unsigned VEC_W     = WIRES * RANK_W;
    localparam int unsigned PAIRS     = WIRES / 2;
    localparam int unsigned ACTIVE    = 4;
    localparam int unsigned POS_BITS  = 6;
    localparam int unsigned SIGN_BITS = 2;
    localparam int unsigned BYTE_W    = POS_BITS + SIGN_BITS;
    localparam int unsigned IDX_W     = 7;

    typedef enum logic [1:0] {
        SYM_ZERO = 2'b00,
        SYM_POS  = 2'b01,
        SYM_NEG  = 2'b10
    } sym_t;

    // Constant helper: n choose k, used only with elaboration-time arguments.
    function automatic int unsigned choose(input int unsigned n, input int unsigned k);
        int unsigned acc;
        acc = 1;
        if (k > n) return 0;
        for (int unsigned i = 0; i < k; i++) begin
            acc = acc * (n - i) / (i + 1);
        end
        return acc;
    endfunction
endpackage

// File: rtl/rank_perm_check.sv
// Module: rank_perm_check
// Flags whether the eight ranks form a permutation of 0..WIRES-1.
// Assumes ranks are exactly RANK_W bits wide, so every value is in range.
module rank_perm_check
    import rank_dec_pkg::*;
(
    input  logic [VEC_W-1:0] rank_vec,
    output logic             is_perm
);
    logic [WIRES-1:0] seen;

    // Mark every rank value that appears; a full mark set means no duplicates.
    always_comb begin
        seen = '0;
        for (int i = 0; i < WIRES; i++) begin
            seen[rank_vec[i*RANK_W +: RANK_W]] = 1'b1;
        end
        is_perm = &seen;
    end
endmodule

// File: rtl/rank_classifier.sv
// Module: rank_classifier
// Turns each wire's rank into a ternary symbol and each wire pair into a bit.
// Assumes rank 0 is the highest level; ranks are not checked here.
module rank_classifier
    import rank_dec_pkg::*;
(
    input  logic [VEC_W-1:0] rank_vec,
    output sym_t [WIRES-1:0] sym,
    output logic [PAIRS-1:0] pair_bits
);
    localparam logic [RANK_W-1:0] TOP_LAST  = RANK_W'(1);
    localparam logic [RANK_W-1:0] BOT_FIRST = RANK_W'(WIRES - 2);

    genvar gw, gp;
    generate
        for (gw = 0; gw < WIRES; gw++) begin : g_wire
            logic [RANK_W-1:0] r;
            assign r = rank_vec[gw*RANK_W +: RANK_W];
            // Top two ranks give +1, bottom two give -1, the rest sit at 0.
            always_comb begin
                if (r <= TOP_LAST)       sym[gw] = SYM_POS;
                else if (r >= BOT_FIRST) sym[gw] = SYM_NEG;
                else                     sym[gw] = SYM_ZERO;
            end
        end
        for (gp = 0; gp < PAIRS; gp++) begin : g_pair
            // The pair bit is 1 when the even wire sorts above its odd partner.
            assign pair_bits[gp] = rank_vec[(2*gp)*RANK_W +: RANK_W]
                                 < rank_vec[(2*gp+1)*RANK_W +: RANK_W];
        end
    endgenerate
endmodule

// File: rtl/subset_decoder.sv
// Module: subset_decoder
// Rebuilds the subset index and sign code from the ternary symbols.
// The index is the colex rank of the non-zero set: sum of C(wire, k) over the
// k-th active wire (k from 1). Assumes a permutation upstream, though the
// active count is checked again here.
module subset_decoder
    import rank_dec_pkg::*;
(
    input  sym_t [WIRES-1:0]     sym,
    output logic [POS_BITS-1:0]  pos_idx,
    output logic [SIGN_BITS-1:0] sign_code,
    output logic                 legal
);
    localparam int unsigned CNT_W = $clog2(WIRES + 1);
    localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(1 << POS_BITS);

    logic [IDX_W-1:0] weight [WIRES][ACTIVE+1];

    genvar gi, gk;
    generate
        for (gi = 0; gi < WIRES; gi++) begin : g_wt_row
            for (gk = 0; gk <= ACTIVE; gk++) begin : g_wt_col
                assign weight[gi][gk] = IDX_W'(choose(gi, gk));
            end
        end
    endgenerate

    logic [CNT_W-1:0]  n_act;
    logic [IDX_W-1:0]  idx_full;
    logic [ACTIVE-1:0] plus_slots;
    logic              sign_ok;

    // Walk the wires in ascending order, summing colex weights and noting +1 slots.
    always_comb begin
        n_act      = '0;
        idx_full   = '0;
        plus_slots = '0;
        for (int i = 0; i < WIRES; i++) begin
            if (sym[i] != SYM_ZERO) begin
                if (n_act < CNT_W'(ACTIVE)) begin
                    idx_full = idx_full + weight[i][n_act + CNT_W'(1)];
                    plus_slots[n_act[1:0]] = (sym[i] == SYM_POS);
                end
                n_act = n_act + CNT_W'(1);
            end
        end
    end

    // Map the +1 slot pattern onto the four allowed sign codes.
    always_comb begin
        sign_ok = 1'b1;
        case (plus_slots)
            4'b0011: sign_code = 2'd0;
            4'b0101: sign_code = 2'd1;
            4'b1001: sign_code = 2'd2;
            4'b0110: sign_code = 2'd3;
            default: begin
                sign_code = 2'd0;
                sign_ok   = 1'b0;
            end
        endcase
    end

    assign pos_idx = idx_full[POS_BITS-1:0];
    assign legal   = (n_act == CNT_W'(ACTIVE)) && (idx_full < IDX_LIMIT) && sign_ok;
endmodule

// File: rtl/err_sat_counter.sv
// Module: err_sat_counter
// Saturating event counter with a synchronous clear that wins over an increment.
module err_sat_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    // Count flagged events, stop at the top value, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n)                   count <= '0;
        else if (clr)                 count <= '0;
        else if (inc && count != TOP) count <= count + W'(1);
    end
endmodule

// File: rtl/rank_codeword_decoder.sv
// Module: rank_codeword_decoder (top)
// Decodes one rank vector per cycle into a byte (code mode) or four pair bits
// (pair mode), with one registered stage. Illegal vectors raise out_err, keep
// the previous byte and advance a saturating counter.
// Assumes control inputs are known whenever rst_n is high.
module rank_codeword_decoder
    import rank_dec_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    mode_legacy,
    input  logic [VEC_W-1:0]        rank_vec,
    input  logic                    err_clr,
    output logic                    out_valid,
    output logic                    out_err,
    output logic [BYTE_W-1:0]       out_data,
    output logic [CNT_W-1:0]        err_count
);
    logic                 is_perm;
    sym_t [WIRES-1:0]     sym;
    logic [PAIRS-1:0]     pair_bits;
    logic [POS_BITS-1:0]  pos_idx;
    logic [SIGN_BITS-1:0] sign_code;
    logic                 code_legal;
    logic                 bad_vec;
    logic [BYTE_W-1:0]    next_byte;

    rank_perm_check u_perm (
        .rank_vec (rank_vec),
        .is_perm  (is_perm)
    );

    rank_classifier u_cls (
        .rank_vec  (rank_vec),
        .sym       (sym),
        .pair_bits (pair_bits)
    );

    subset_decoder u_sub (
        .sym       (sym),
        .pos_idx   (pos_idx),
        .sign_code (sign_code),
        .legal     (code_legal)
    );

    // Choose the error condition and the result word for the active mode.
    always_comb begin
        if (mode_legacy) begin
            bad_vec   = !is_perm;
            next_byte = {(BYTE_W-PAIRS)'(0), pair_bits};
        end else begin
            bad_vec   = !(is_perm && code_legal);
            next_byte = {pos_idx, sign_code};
        end
    end

    // Output stage: valid follows input, byte updates only on a good vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_err   <= in_valid && bad_vec;
            if (in_valid && !bad_vec) out_data <= next_byte;
        end
    end

    err_sat_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (in_valid && bad_vec),
        .clr   (err_clr),
        .count (err_count)
    );
endmodule

// File: rtl/rank_codeword_decoder_chk.sv
// Module: rank_codeword_decoder_chk
// Temporal checks on the decoder's ports, attached to every instance by bind.
module rank_codeword_decoder_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             mode_legacy,
    input logic             err_clr,
    input logic             out_valid,
    input logic             out_err,
    input logic [7:0]       out_data,
    input logic [CNT_W-1:0] err_count
);
    localparam logic [CNT_W-1:0] TOP = '1;

    a_r7_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r7_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && $past(rst_n)) |-> $stable(out_data));
    a_r8_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_valid);
    a_r4_hold_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        (out_err && $past(rst_n)) |-> $stable(out_data));
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err && $past(mode_legacy)) |-> out_data[7:4] == 4'd0);
    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == TOP && !err_clr) |=> err_count == TOP);
    a_r9_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> err_count >= $past(err_count));
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> err_count == '0);
endmodule

bind rank_codeword_decoder rank_codeword_decoder_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .mode_legacy (mode_legacy),
    .err_clr     (err_clr),
    .out_valid   (out_valid),
    .out_err     (out_err),
    .out_data    (out_data),
    .err_count   (err_count)
);

// File: tb/tb_rank_codeword_decoder.sv
module tb_rank_codeword_decoder;
    localparam int CNT_W = 8;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic mode_legacy = 1'b0;
    logic [23:0] rank_vec = '0;
    logic err_clr = 1'b0;
    logic out_valid, out_err;
    logic [7:0] out_data;
    logic [CNT_W-1:0] err_count;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string tag_in = "R11";

    always #5 clk = ~clk;

    rank_codeword_decoder #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_legacy(mode_legacy),
        .rank_vec(rank_vec), .err_clr(err_clr), .out_valid(out_valid),
        .out_err(out_err), .out_data(out_data), .err_count(err_count)
    );

    // Behavioural reference decode, written from the requirements.
    function automatic void model_decode(input logic [23:0] r, input logic leg,
                                         output bit err, output logic [7:0] d);
        int cnt [8];
        int rk [8];
        int plus_at [4];
        int np, k, idx;
        logic [7:0] mask;
        err = 0; d = '0;
        for (int v = 0; v < 8; v++) cnt[v] = 0;
        for (int i = 0; i < 8; i++) begin rk[i] = int'(r[3*i +: 3]); cnt[rk[i]]++; end
        for (int v = 0; v < 8; v++) if (cnt[v] != 1) err = 1;
        if (err) return;
        if (leg) begin
            for (int j = 0; j < 4; j++) d[j] = (rk[2*j] < rk[2*j+1]);
            return;
        end
        mask = '0;
        for (int i = 0; i < 8; i++) if (rk[i] <= 1 || rk[i] >= 6) mask[i] = 1'b1;
        idx = 0;
        for (int m = 0; m < int'(mask); m++) if ($countones(m) == 4) idx++;
        np = 0; k = 0;
        for (int i = 0; i < 8; i++) if (mask[i]) begin
            if (rk[i] <= 1) begin plus_at[np] = k; np++; end
            k++;
        end
        if (idx >= 64) err = 1;
        if (plus_at[0] == 0 && plus_at[1] == 1)      d[1:0] = 2'd0;
        else if (plus_at[0] == 0 && plus_at[1] == 2) d[1:0] = 2'd1;
        else if (plus_at[0] == 0 && plus_at[1] == 3) d[1:0] = 2'd2;
        else if (plus_at[0] == 1 && plus_at[1] == 2) d[1:0] = 2'd3;
        else err = 1;
        d[7:2] = idx[5:0];
    endfunction

    // Reference state, advanced on every clock.
    bit m_valid, m_err;
    logic [7:0] m_data;
    int m_cnt;
    string m_tag = "R11";
    bit e_now;
    logic [7:0] d_now;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 0; m_err <= 0; m_data <= '0; m_cnt <= 0;
        end else begin
            model_decode(rank_vec, mode_legacy, e_now, d_now);
            m_valid <= in_valid;
            m_err   <= in_valid && e_now;
            if (in_valid && !e_now) m_data <= d_now;
            if (err_clr) m_cnt <= 0;
            else if (in_valid && e_now && m_cnt < CMAX) m_cnt <= m_cnt + 1;
        end
        m_tag <= tag_in;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare();
        string creq;
        creq = (m_tag == "R10" || m_tag == "R11") ? m_tag : "R9";
        check(out_valid === m_valid, (m_tag == "R11") ? "R11" : "R7", "out_valid",
              int'(out_valid), int'(m_valid));
        check(out_err === m_err, (m_tag == "R11") ? "R11" : "R8", "out_err",
              int'(out_err), int'(m_err));
        check(out_data === m_data, m_tag, "out_data", int'(out_data), int'(m_data));
        check(int'(err_count) == m_cnt && !$isunknown(err_count), creq, "err_count",
              int'(err_count), m_cnt);
    endtask

    task automatic step(input logic [23:0] v, input logic leg, input logic vld,
                        input logic clr, input string tag);
        @(negedge clk);
        compare();
        rank_vec = v; mode_legacy = leg; in_valid = vld; err_clr = clr; tag_in = tag;
    endtask

    // The n-th 8-bit mask with four set bits, in increasing numeric order.
    function automatic logic [7:0] nth_mask(input int n);
        int seen = 0;
        for (int m = 0; m < 256; m++) if ($countones(m) == 4) begin
            if (seen == n) return 8'(m);
            seen++;
        end
        return 8'h0F;
    endfunction

    // Ranks from an active mask and a +1 slot pattern; rot shuffles within classes.
    function automatic logic [23:0] build_raw(input logic [7:0] mask, input logic [3:0] plus4,
                                             input int rot);
        logic [23:0] r = '0;
        int k = 0, pi = 0, ni = 0, zi = 0;
        int rv;
        for (int i = 0; i < 8; i++) begin
            if (mask[i]) begin
                if (plus4[k]) begin rv = pi ^ (rot & 1); pi++; end
                else begin rv = 6 + (ni ^ ((rot >> 1) & 1)); ni++; end
                k++;
            end else begin
                rv = 2 + ((zi + rot) % 4); zi++;
            end
            r[3*i +: 3] = 3'(rv);
        end
        return r;
    endfunction

    function automatic logic [23:0] build_code(input logic [7:0] b, input int rot);
        logic [3:0] p;
        case (b[1:0])
            2'd0: p = 4'b0011;
            2'd1: p = 4'b0101;
            2'd2: p = 4'b1001;
            default: p = 4'b0110;
        endcase
        return build_raw(nth_mask(int'(b[7:2])), p, rot);
    endfunction

    function automatic logic [23:0] rand_perm();
        int a [8];
        int j, t;
        logic [23:0] r;
        for (int i = 0; i < 8; i++) a[i] = i;
        for (int i = 7; i > 0; i--) begin
            j = int'($urandom_range(i, 0)); t = a[i]; a[i] = a[j]; a[j] = t;
        end
        for (int i = 0; i < 8; i++) r[3*i +: 3] = 3'(a[i]);
        return r;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [23:0] v;
        // R11: reset state over several edges.
        repeat (3) step(24'hFFFFFF, 1'b0, 1'b1, 1'b0, "R11");
        @(negedge clk); compare(); rst_n = 1'b1;
        // R1: every byte once.
        for (int b = 0; b < 256; b++) step(build_code(8'(b), b), 1'b0, 1'b1, 1'b0, "R1");
        // R2: each sign code across a few subsets.
        for (int s = 0; s < 4; s++) for (int q = 0; q < 64; q += 21)
            step(build_code(8'((q << 2) | s), s), 1'b0, 1'b1, 1'b0, "R2");
        // R3: same byte, ranks rearranged within classes.
        for (int b = 3; b < 256; b += 37) for (int rot = 0; rot < 4; rot++)
            step(build_code(8'(b), rot), 1'b0, 1'b1, 1'b0, "R3");
        // R7: idle cycles with junk ranks must not move the byte.
        for (int i = 0; i < 6; i++) step(rand_perm(), 1'b0, 1'b0, 1'b0, "R7");
        step(24'h000000, 1'b1, 1'b0, 1'b0, "R7");
        // R4: duplicated ranks in both modes.
        step(build_code(8'h5A, 0), 1'b0, 1'b1, 1'b0, "R4");
        step(24'h000000, 1'b0, 1'b1, 1'b0, "R4");
        v = build_code(8'hC3, 1); v[2:0] = v[5:3];
        step(v, 1'b0, 1'b1, 1'b0, "R4");
        step(v, 1'b1, 1'b1, 1'b0, "R4");
        // R5: subset index at and beyond 64, and disallowed +1 slots.
        for (int n = 64; n < 70; n++) step(build_raw(nth_mask(n), 4'b0011, n), 1'b0, 1'b1, 1'b0, "R5");
        step(build_code(8'hFF, 2), 1'b0, 1'b1, 1'b0, "R5");
        step(build_raw(8'h0F, 4'b1010, 0), 1'b0, 1'b1, 1'b0, "R5");
        step(build_raw(8'h0F, 4'b1100, 3), 1'b0, 1'b1, 1'b0, "R5");
        step(build_raw(nth_mask(63), 4'b1010, 1), 1'b0, 1'b1, 1'b0, "R5");
        // R6: pair mode over random orderings.
        for (int i = 0; i < 40; i++) step(rand_perm(), 1'b1, 1'b1, 1'b0, "R6");
        // R8: alternate good and bad vectors.
        for (int i = 0; i < 6; i++)
            step((i % 2) ? 24'h249249 : build_code(8'(i * 40), i), 1'b0, 1'b1, 1'b0, "R8");
        // R9: drive past saturation.
        for (int i = 0; i < CMAX + 6; i++) step(24'h000000, 1'b0, 1'b1, 1'b0, "R9");
        step(build_code(8'h11, 0), 1'b0, 1'b1, 1'b0, "R9");
        // R10: clear alone, then clear against a flagged vector.
        step(build_code(8'h22, 0), 1'b0, 1'b0, 1'b1, "R10");
        step(24'h000000, 1'b0, 1'b1, 1'b0, "R10");
        step(24'h000000, 1'b0, 1'b1, 1'b1, "R10");
        step(24'h000000, 1'b0, 1'b0, 1'b0, "R10");
        step(24'h000000, 1'b0, 1'b0, 1'b0, "R10");
        done = 1;
        summary();
        $finish;
    end
endmodule